// File: doc/BRIEF.md
# Flash Erase Command Sequencer

This block connects to the special-function-register bus of a small microcontroller and turns register writes into erase requests for a flash controller. Software first loads a page number, or arms whole-array erase, and then writes a command byte. The block accepts only two command codes. Each code must follow its own prerequisite write. Whole-array erase also needs the debug-enable input to be high.

An accepted command produces a one-cycle request toward the flash controller. The request carries the page number and a flag that selects a whole-array erase. The block then stays in progress until the controller's busy line has risen and fallen again. While it is in progress, command writes are dropped. A status register shows the in-progress state and whether the last recognised command was refused for a missing prerequisite.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset the page register reads 0x00, both arm flags are clear, the status register reads 0x00 and no erase request is raised.
- R2: The page register (address 0x10) stores the low 7 bits of a write. A read returns them with bit 7 as zero. Every page write arms a page erase.
- R3: Writing 0x55 to the command register (address 0x12) while a page erase is armed raises `erase_req` for exactly one cycle. The request is raised on the cycle after the write edge, with `erase_mass`=0 and `erase_page` equal to the stored page.
- R4: An accepted page erase uses up its arming. A second 0x55 with no fresh page write gives no request and sets the rejected bit.
- R5: Writing 0xAA while whole-array erase is armed (any write to address 0x11) and `debug_en` is high raises a one-cycle `erase_req` with `erase_mass`=1. The arming is used up.
- R6: A 0xAA write with `debug_en` low, or with no arming, gives no request and sets the rejected bit. A refusal caused by `debug_en` does not clear the arming.
- R7: A command byte other than 0x55 or 0xAA gives no request and leaves the rejected bit and both arm flags unchanged.
- R8: The in-progress bit (status bit 0) sets together with `erase_req`. It clears on the cycle after `fc_busy` falls, having first been seen high. Commands written while it is set, or while `fc_busy` is high, are dropped, but register writes still arm.
- R9: The command register reads 0x00. The arm register (address 0x11) reads its flag in bit 0. The status register (address 0x13) has in-progress in bit 0 and rejected in bit 1.
- R10: An accepted command clears the rejected bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| debug_en | input | 1 | Debug port enabled; permits whole-array erase |
| fc_busy | input | 1 | Flash controller busy |
| erase_req | output | 1 | One-cycle erase request |
| erase_mass | output | 1 | Request is a whole-array erase |
| erase_page | output | 7 | Page number of a page erase |

## Verification
A command write captured at clock edge k raises `erase_req` and the in-progress bit between edges k and k+1. The bench drives each write on a falling edge and samples at the following falling edge, so it sees the pulse. It then checks one falling edge later that the pulse has gone. Register reads are combinational, so they are sampled one time step after the address changes. After `fc_busy` drops, the bench waits one full clock before it expects the in-progress bit to clear. Refused and dropped commands are checked at the request output at the due cycle. The bench also reads the status register, and it uses a later command to show the arming that survived.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
  localparam logic [7:0] CMD_PAGE_ERASE = 8'h55;
  localparam logic [7:0] CMD_MASS_ERASE = 8'hAA;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_BUSY   = 2'd2
  } seq_state_t;
endpackage

// File: rtl/flash_erase_regs.sv
module flash_erase_regs #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 7,
  parameter logic [ADDR_W-1:0] A_PAGE = 8'h10,
  parameter logic [ADDR_W-1:0] A_ARM  = 8'h11,
  parameter logic [ADDR_W-1:0] A_CMD  = 8'h12,
  parameter logic [ADDR_W-1:0] A_STAT = 8'h13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              page_use,
  input  logic              mass_use,
  input  logic              busy_flag,
  input  logic              rej_flag,
  output logic [PAGE_W-1:0] page_q,
  output logic              page_armed,
  output logic              mass_armed,
  output logic [DATA_W-1:0] rdata
);
  logic              page_we, arm_we;
  logic [PAGE_W-1:0] page_d;
  logic              page_armed_d, mass_armed_d;

  assign page_we = wr && (addr == A_PAGE);
  assign arm_we  = wr && (addr == A_ARM);

  always_comb begin
    page_d       = page_we ? wdata[PAGE_W-1:0] : page_q;
    page_armed_d = page_we ? 1'b1 : (page_use ? 1'b0 : page_armed);
    mass_armed_d = arm_we  ? 1'b1 : (mass_use ? 1'b0 : mass_armed);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q     <= '0;
      page_armed <= 1'b0;
      mass_armed <= 1'b0;
    end else begin
      if (page_we) page_q <= page_d;
      page_armed <= page_armed_d;
      mass_armed <= mass_armed_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_PAGE)      rdata = {{(DATA_W-PAGE_W){1'b0}}, page_q};
    else if (addr == A_ARM)  rdata = {{(DATA_W-1){1'b0}}, mass_armed};
    else if (addr == A_STAT) rdata = {{(DATA_W-2){1'b0}}, rej_flag, busy_flag};
  end

  // R4
  page_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (page_use && !page_we) |=> !page_armed);
  // R5
  mass_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mass_use && !arm_we) |=> !mass_armed);
endmodule

// File: rtl/flash_erase_decode.sv
module flash_erase_decode
  import flash_erase_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] cmd,
  input  logic              page_armed,
  input  logic              mass_armed,
  input  logic              debug_en,
  output logic              page_go,
  output logic              mass_go,
  output logic              reject
);
  logic is_page, is_mass;

  always_comb begin
    is_page = cmd_wr && (cmd == CMD_PAGE_ERASE);
    is_mass = cmd_wr && (cmd == CMD_MASS_ERASE);
    page_go = is_page && page_armed;
    mass_go = is_mass && mass_armed && debug_en;
    reject  = (is_page && !page_armed) || (is_mass && !(mass_armed && debug_en));
  end

  // R7
  always_comb begin
    if (cmd_wr && !is_page && !is_mass)
      other_byte_chk: assert (!page_go && !mass_go && !reject);
  end
endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
  import flash_erase_pkg::*;
#(
  parameter int PAGE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              page_go,
  input  logic              mass_go,
  input  logic              reject,
  input  logic [PAGE_W-1:0] page_in,
  input  logic              fc_busy,
  input  logic              debug_en,
  output logic              idle,
  output logic              in_progress,
  output logic              rejected,
  output logic              req,
  output logic              req_mass,
  output logic [PAGE_W-1:0] req_page
);
  seq_state_t  state_q, state_d;
  logic        go;
  logic        req_d, mass_d, rej_d;
  logic [PAGE_W-1:0] page_d;

  assign go          = page_go || mass_go;
  assign idle        = (state_q == ST_IDLE) && !fc_busy;
  assign in_progress = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (go)       state_d = ST_WAIT;
      ST_WAIT: if (fc_busy)  state_d = ST_BUSY;
      ST_BUSY: if (!fc_busy) state_d = ST_IDLE;
      default:               state_d = ST_IDLE;
    endcase
    req_d  = go;
    mass_d = go ? mass_go : req_mass;
    page_d = page_go ? page_in : (mass_go ? '0 : req_page);
    rej_d  = reject ? 1'b1 : (go ? 1'b0 : rejected);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      req      <= 1'b0;
      req_mass <= 1'b0;
      req_page <= '0;
      rejected <= 1'b0;
    end else begin
      state_q  <= state_d;
      req      <= req_d;
      rejected <= rej_d;
      if (go) begin
        req_mass <= mass_d;
        req_page <= page_d;
      end
    end
  end

  // R3
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req);
  // R8
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> in_progress);
  // R8
  req_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> !$past(in_progress));
  // R5
  mass_debug_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && req_mass) |-> $past(debug_en));
  // R10
  rej_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> !rejected);
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 7,
  parameter logic [ADDR_W-1:0] A_PAGE = 8'h10,
  parameter logic [ADDR_W-1:0] A_ARM  = 8'h11,
  parameter logic [ADDR_W-1:0] A_CMD  = 8'h12,
  parameter logic [ADDR_W-1:0] A_STAT = 8'h13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              debug_en,
  input  logic              fc_busy,
  output logic              erase_req,
  output logic              erase_mass,
  output logic [PAGE_W-1:0] erase_page
);
  logic [1:0]        rst_sync;
  logic              rst_ni;
  logic              page_go, mass_go, reject, idle, in_prog, rej;
  logic              page_armed, mass_armed, cmd_wr;
  logic [PAGE_W-1:0] page_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  assign cmd_wr = reg_wr && (reg_addr == A_CMD) && idle;

  flash_erase_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W),
    .A_PAGE(A_PAGE), .A_ARM(A_ARM), .A_CMD(A_CMD), .A_STAT(A_STAT)
  ) regs_i (
    .clk(clk), .rst_n(rst_ni), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .page_use(page_go), .mass_use(mass_go), .busy_flag(in_prog), .rej_flag(rej),
    .page_q(page_q), .page_armed(page_armed), .mass_armed(mass_armed),
    .rdata(reg_rdata)
  );

  flash_erase_decode #(.DATA_W(DATA_W)) dec_i (
    .cmd_wr(cmd_wr), .cmd(reg_wdata), .page_armed(page_armed),
    .mass_armed(mass_armed), .debug_en(debug_en),
    .page_go(page_go), .mass_go(mass_go), .reject(reject)
  );

  flash_erase_ctrl #(.PAGE_W(PAGE_W)) ctrl_i (
    .clk(clk), .rst_n(rst_ni), .page_go(page_go), .mass_go(mass_go),
    .reject(reject), .page_in(page_q), .fc_busy(fc_busy), .debug_en(debug_en),
    .idle(idle), .in_progress(in_prog), .rejected(rej),
    .req(erase_req), .req_mass(erase_mass), .req_page(erase_page)
  );

  // R8
  drop_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (fc_busy || in_prog) |=> !$rose(erase_req));
endmodule

// File: tb/flash_erase_seq_tb.sv
`timescale 1ns/100ps
module flash_erase_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       debug_en = 1'b0;
  logic       fc_busy = 1'b0;
  logic       erase_req, erase_mass;
  logic [6:0] erase_page;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done = 1'b0;

  localparam logic [7:0] A_PAGE = 8'h10, A_ARM = 8'h11, A_CMD = 8'h12, A_STAT = 8'h13;

  always #2.5 clk = ~clk;

  flash_erase_seq dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .debug_en(debug_en),
    .fc_busy(fc_busy), .erase_req(erase_req), .erase_mass(erase_mass),
    .erase_page(erase_page)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Write lands on the next rising edge; returns at the following falling edge.
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic expect_req(input string tag, input bit mass, input logic [6:0] pg);
    check(erase_req === 1'b1, tag, erase_req, 1);
    check(erase_mass === mass, tag, erase_mass, mass);
    if (!mass) check(erase_page === pg, tag, erase_page, pg);
    @(negedge clk);
    check(erase_req === 1'b0, {tag, " pulse width"}, erase_req, 0);
  endtask

  task automatic handshake(input string tag);
    logic [7:0] s;
    @(negedge clk) fc_busy = 1'b1;
    @(negedge clk);
    rd(A_STAT, s);
    check(s[0] === 1'b1, tag, s, 1);
    fc_busy = 1'b0;
    @(negedge clk);
    rd(A_STAT, s);
    check(s[0] === 1'b0, tag, s[0], 0);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(A_PAGE, v); check(v === 8'h00, "R1 page", v, 0);
    rd(A_ARM, v);  check(v === 8'h00, "R1 arm", v, 0);
    rd(A_STAT, v); check(v === 8'h00, "R1 status", v, 0);
    check(erase_req === 1'b0, "R1 req", erase_req, 0);
    rd(A_CMD, v);  check(v === 8'h00, "R9 cmd read", v, 0);
  endtask

  task automatic t_page_reg();
    logic [7:0] v;
    wr(A_PAGE, 8'hFF); rd(A_PAGE, v); check(v === 8'h7F, "R2 top bit", v, 8'h7F);
    wr(A_PAGE, 8'h25); rd(A_PAGE, v); check(v === 8'h25, "R2 value", v, 8'h25);
  endtask

  task automatic t_page_erase();
    logic [7:0] v;
    wr(A_CMD, 8'h55);
    rd(A_STAT, v); check(v === 8'h01, "R8 status in progress", v, 1);
    expect_req("R3 page erase", 1'b0, 7'h25);
    handshake("R8 handshake");
  endtask

  task automatic t_page_repeat();
    logic [7:0] v;
    wr(A_CMD, 8'h55);
    check(erase_req === 1'b0, "R4 no rearm", erase_req, 0);
    rd(A_STAT, v); check(v === 8'h02, "R4 rejected", v, 2);
  endtask

  task automatic t_other_byte();
    logic [7:0] v;
    wr(A_PAGE, 8'h11);
    wr(A_CMD, 8'h12);
    check(erase_req === 1'b0, "R7 no req", erase_req, 0);
    rd(A_STAT, v); check(v === 8'h02, "R7 rejected kept", v, 2);
    wr(A_CMD, 8'h55);
    rd(A_STAT, v); check(v[1] === 1'b0, "R10 rejected cleared", v, 0);
    expect_req("R7 arm kept", 1'b0, 7'h11);
    handshake("R8 handshake 2");
  endtask

  task automatic t_mass();
    logic [7:0] v;
    debug_en = 1'b0;
    wr(A_ARM, 8'h01);
    rd(A_ARM, v); check(v === 8'h01, "R9 arm read", v, 1);
    wr(A_CMD, 8'hAA);
    check(erase_req === 1'b0, "R6 debug off", erase_req, 0);
    rd(A_STAT, v); check(v === 8'h02, "R6 rejected", v, 2);
    debug_en = 1'b1;
    wr(A_CMD, 8'hAA);
    expect_req("R5 mass erase", 1'b1, 7'h00);
    handshake("R8 handshake 3");
    rd(A_ARM, v); check(v === 8'h00, "R5 arm used", v, 0);
    wr(A_CMD, 8'hAA);
    check(erase_req === 1'b0, "R6 not armed", erase_req, 0);
    rd(A_STAT, v); check(v === 8'h02, "R6 rejected again", v, 2);
  endtask

  task automatic t_busy_drop();
    logic [7:0] v;
    wr(A_PAGE, 8'h05);
    wr(A_CMD, 8'h55);
    expect_req("R3 page 5", 1'b0, 7'h05);
    wr(A_PAGE, 8'h06);
    wr(A_CMD, 8'h55);
    check(erase_req === 1'b0, "R8 dropped in progress", erase_req, 0);
    rd(A_STAT, v); check(v === 8'h01, "R8 status unchanged", v, 1);
    handshake("R8 handshake 4");
    fc_busy = 1'b1;
    wr(A_CMD, 8'h55);
    check(erase_req === 1'b0, "R8 dropped on fc_busy", erase_req, 0);
    fc_busy = 1'b0;
    wr(A_CMD, 8'h55);
    expect_req("R8 arm survives", 1'b0, 7'h06);
    handshake("R8 handshake 5");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_page_reg();
    t_page_erase();
    t_page_repeat();
    t_other_byte();
    t_mass();
    t_busy_drop();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule